// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with High-Word Register

This unit performs 32-bit integer multiplication and division for a small processor datapath. A multiply takes the destination operand and a source operand, either as two's-complement or as unsigned values, and forms a 64-bit product. The low word of the product returns as the new destination value. The high word is kept in a dedicated high-word register inside the unit.

A divide uses a 64-bit dividend made of the high-word register (upper half) and the destination operand (lower half). The source operand is the divisor. The quotient returns as the new destination value and the remainder lands in the high-word register. The divide runs one quotient bit per cycle. The multiply finishes after a fixed number of cycles. A zero divisor, or a quotient too wide for 32 bits, raises an error and changes no state.

Every successful operation updates a small flag group. Zero and negative are taken from the destination result only, and carry and overflow are cleared. The surrounding datapath starts an operation with a one-cycle `start` strobe, waits for `done`, and can load or read the high-word register directly while the unit is idle.

Top module: `muldiv_unit`

## Requirements
- R1: An unsigned multiply (opSel=0, isSigned=0) sets dstOut to product bits 31:0 and hiRd to product bits 63:32, placed in hiRd bits 31:0.
- R2: A signed multiply (opSel=0, isSigned=1) treats both operands as two's-complement and splits the 64-bit signed product in the same way as R1.
- R3: An unsigned divide (opSel=1, isSigned=0) divides the 64-bit value {hiRd, dstIn} by srcIn, puts the quotient on dstOut and the remainder on hiRd.
- R4: A signed divide (opSel=1, isSigned=1) truncates the quotient toward zero, and the remainder takes the sign of the dividend.
- R5: After a successful operation, flags bit 0 (zero) is set exactly when dstOut is zero, flags bit 1 (negative) equals dstOut bit 31, and flags bits 2 (carry) and 3 (overflow) are 0.
- R6: A divide with srcIn equal to zero raises divErr together with done, and leaves dstOut, hiRd and flags unchanged.
- R7: A divide whose quotient magnitude does not fit in 32 bits (the magnitude of the dividend's upper word is at least the magnitude of the divisor) is handled as in R6.
- R8: done is a one-cycle pulse that is first seen 2 clock edges after the start edge for a multiply (default MUL_CYCLES), 33 edges after it for a divide, and 1 edge after it for a faulting divide. busy is high from the start edge until the completing edge.
- R9: With busy low and start low, a hiWrEn pulse loads hiWrData into the high-word register, which is visible on hiRd after that edge.
- R10: While busy is high, start and hiWrEn are ignored: the running operation keeps its timing and results and the high-word register is not loaded.
- R11: After reset, dstOut, hiRd and flags are zero and busy, done and divErr are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| opSel | input | 1 | 0 = multiply, 1 = divide |
| isSigned | input | 1 | 1 = two's-complement operands |
| dstIn | input | 32 | Destination operand / low dividend word |
| srcIn | input | 32 | Second operand / divisor |
| hiWrEn | input | 1 | Load the high-word register (idle only) |
| hiWrData | input | 32 | Value for the high-word register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| divErr | output | 1 | Divide fault, valid with done |
| dstOut | output | 32 | Result for the destination register |
| hiRd | output | 32 | Current high-word register value |
| flags | output | 4 | {overflow, carry, negative, zero} |

## Verification
Assertions watch, on every cycle, that done is a lone pulse, that a fault never alters the destination result or the high-word register, that the high-word register holds still throughout an operation, that the flags follow the written result, that the partial remainder stays below the divisor on each step, and that only one datapath strobe is active at a time. Arithmetic correctness of products, quotients and remainders under both signednesses, the exact completion latencies, and the rejection of strobes arriving mid-operation can only be shown by the bench's directed scenarios, which compare against values computed with wide integer arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_FIX,
    ST_FLT
  } mdState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands, prepare divide
    logic mulWr;    // commit product
    logic divStep;  // one restoring-division step
    logic divWr;    // sign-fix and commit quotient/remainder
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MUL_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      opSel,
  input  logic      divFault,
  output mdStrobe_t strb,
  output logic      busy,
  output logic      done,
  output logic      divErr
);

  localparam int DIV_STEPS = WIDTH;
  localparam int CNT_MAX   = (DIV_STEPS > MUL_CYCLES) ? DIV_STEPS : MUL_CYCLES;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  mdState_e         stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             doneQ, doneD;
  logic             errQ, errD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    doneD  = 1'b0;
    errD   = 1'b0;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          if (mdOp_e'(opSel) == OP_DIV) begin
            if (divFault) begin
              stateD = ST_FLT;
            end else begin
              stateD = ST_DIV;
              cntD   = CNT_W'(DIV_STEPS - 1);
            end
          end else begin
            stateD = ST_MUL;
            cntD   = CNT_W'(MUL_CYCLES - 1);
          end
        end
      end
      ST_MUL: begin
        if (cntQ == '0) begin
          strb.mulWr = 1'b1;
          doneD      = 1'b1;
          stateD     = ST_IDLE;
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      ST_DIV: begin
        strb.divStep = 1'b1;
        if (cntQ == '0) stateD = ST_FIX;
        else            cntD   = cntQ - CNT_W'(1);
      end
      ST_FIX: begin
        strb.divWr = 1'b1;
        doneD      = 1'b1;
        stateD     = ST_IDLE;
      end
      ST_FLT: begin
        doneD  = 1'b1;
        errD   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;
  assign divErr = errQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> done);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.mulWr, strb.divStep, strb.divWr}));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strb,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic             hiWrEn,
  input  logic             hiWrOk,
  input  logic [WIDTH-1:0] hiWrData,
  output logic             divFault,
  output logic [WIDTH-1:0] dstOut,
  output logic [WIDTH-1:0] hiRd,
  output logic [3:0]       flags
);

  localparam int DW = 2 * WIDTH;

  // captured operands
  logic [WIDTH-1:0] aQ, bQ;
  logic             sgnQ;
  // divide state
  logic [WIDTH-1:0] remQ, quoQ, dvsQ;
  logic             negQuoQ, negRemQ;
  // architectural results
  logic [WIDTH-1:0] mdrQ, dstQ;
  logic [3:0]       flagsQ;

  // ---------------- divide setup ----------------
  logic [DW-1:0]    dvdRaw, dvdMag;
  logic             dvdNeg, dvsNeg;
  logic [WIDTH-1:0] dvsMag;

  assign dvdRaw   = {mdrQ, dstIn};
  assign dvdNeg   = isSigned & mdrQ[WIDTH-1];
  assign dvdMag   = dvdNeg ? (~dvdRaw + DW'(1)) : dvdRaw;
  assign dvsNeg   = isSigned & srcIn[WIDTH-1];
  assign dvsMag   = dvsNeg ? (~srcIn + WIDTH'(1)) : srcIn;
  assign divFault = (srcIn == '0) | (dvdMag[DW-1:WIDTH] >= dvsMag);

  // ---------------- restoring step ----------------
  logic [WIDTH:0] trial, diff;
  logic           take;

  assign trial = {remQ, quoQ[WIDTH-1]};
  assign diff  = trial - {1'b0, dvsQ};
  assign take  = ~diff[WIDTH];

  // ---------------- multiply ----------------
  logic [WIDTH:0]        extA, extB;
  logic signed [DW-1:0]  prodFull;

  assign extA     = {sgnQ & aQ[WIDTH-1], aQ};
  assign extB     = {sgnQ & bQ[WIDTH-1], bQ};
  assign prodFull = $signed(extA) * $signed(extB);

  // ---------------- commit mux ----------------
  logic [WIDTH-1:0] quoFix, remFix, wrLo, wrHi;
  logic             commit;

  assign quoFix = negQuoQ ? (~quoQ + WIDTH'(1)) : quoQ;
  assign remFix = negRemQ ? (~remQ + WIDTH'(1)) : remQ;
  assign wrLo   = strb.divWr ? quoFix : prodFull[WIDTH-1:0];
  assign wrHi   = strb.divWr ? remFix : prodFull[DW-1:WIDTH];
  assign commit = strb.mulWr | strb.divWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ      <= '0;
      bQ      <= '0;
      sgnQ    <= 1'b0;
      remQ    <= '0;
      quoQ    <= '0;
      dvsQ    <= '0;
      negQuoQ <= 1'b0;
      negRemQ <= 1'b0;
    end else if (strb.load) begin
      aQ      <= dstIn;
      bQ      <= srcIn;
      sgnQ    <= isSigned;
      remQ    <= dvdMag[DW-1:WIDTH];
      quoQ    <= dvdMag[WIDTH-1:0];
      dvsQ    <= dvsMag;
      negQuoQ <= dvdNeg ^ dvsNeg;
      negRemQ <= dvdNeg;
    end else if (strb.divStep) begin
      remQ <= take ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
      quoQ <= {quoQ[WIDTH-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdrQ   <= '0;
      dstQ   <= '0;
      flagsQ <= '0;
    end else if (commit) begin
      dstQ   <= wrLo;
      mdrQ   <= wrHi;
      flagsQ <= {1'b0, 1'b0, wrLo[WIDTH-1], (wrLo == '0)};
    end else if (hiWrEn && hiWrOk) begin
      mdrQ <= hiWrData;
    end
  end

  assign dstOut = dstQ;
  assign hiRd   = mdrQ;
  assign flags  = flagsQ;

  // R5
  flag_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> (flags[0] == (dstOut == '0)) && (flags[1] == dstOut[WIDTH-1]));

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.divStep |-> (remQ < dvsQ));

  // R6
  no_commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(dstOut) && $stable(flags));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MUL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opSel,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic             hiWrEn,
  input  logic [WIDTH-1:0] hiWrData,
  output logic             busy,
  output logic             done,
  output logic             divErr,
  output logic [WIDTH-1:0] dstOut,
  output logic [WIDTH-1:0] hiRd,
  output logic [3:0]       flags
);

  mdStrobe_t strb;
  logic      divFault;
  logic      hiWrOk;

  assign hiWrOk = ~busy & ~start;

  muldiv_ctrl #(
    .WIDTH      (WIDTH),
    .MUL_CYCLES (MUL_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opSel    (opSel),
    .divFault (divFault),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .divErr   (divErr)
  );

  muldiv_dp #(
    .WIDTH (WIDTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .isSigned (isSigned),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .hiWrEn   (hiWrEn),
    .hiWrOk   (hiWrOk),
    .hiWrData (hiWrData),
    .divFault (divFault),
    .dstOut   (dstOut),
    .hiRd     (hiRd),
    .flags    (flags)
  );

  // R6 R7
  fault_no_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> $stable(dstOut) && $stable(hiRd) && $stable(flags));

  // R10
  hi_hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done || $stable(hiRd)));

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opSel = 1'b0;
  logic        isSigned = 1'b0;
  logic [31:0] dstIn = '0;
  logic [31:0] srcIn = '0;
  logic        hiWrEn = 1'b0;
  logic [31:0] hiWrData = '0;
  logic        busy, done, divErr;
  logic [31:0] dstOut, hiRd;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .isSigned(isSigned),
    .dstIn(dstIn), .srcIn(srcIn), .hiWrEn(hiWrEn), .hiWrData(hiWrData),
    .busy(busy), .done(done), .divErr(divErr), .dstOut(dstOut), .hiRd(hiRd),
    .flags(flags)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expFlags(logic [31:0] v);
    return {2'b00, v[31], (v == 32'd0)};
  endfunction

  function automatic logic [63:0] expMul(bit sgn, logic [31:0] a, logic [31:0] b);
    longint p;
    if (sgn) begin
      p = longint'($signed(a)) * longint'($signed(b));
      return 64'(p);
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  task automatic expDiv(input bit sgn, input logic [31:0] hi, input logic [31:0] lo,
                        input logic [31:0] dv, output bit flt,
                        output logic [31:0] q, output logic [31:0] r);
    logic [63:0] dvd;
    dvd = {hi, lo};
    flt = 1'b0; q = '0; r = '0;
    if (dv == 32'd0) begin
      flt = 1'b1;
    end else if (!sgn) begin
      logic [63:0] q64;
      q64 = dvd / {32'd0, dv};
      flt = (q64[63:32] != 32'd0);
      q   = q64[31:0];
      r   = 32'(dvd % {32'd0, dv});
    end else begin
      longint sd, sv, qq, rr, mq;
      sd = longint'(dvd);
      sv = longint'($signed(dv));
      qq = sd / sv;
      rr = sd % sv;
      mq = (qq < 0) ? -qq : qq;
      flt = (mq >= 64'sh1_0000_0000);
      q = 32'(qq);
      r = 32'(rr);
    end
  endtask

  // Run one operation; returns edges from start edge to done
  task automatic runOp(bit div, bit sgn, logic [31:0] a, logic [31:0] b, output int lat);
    @(negedge clk);
    start = 1'b1; opSel = div; isSigned = sgn; dstIn = a; srcIn = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic writeHi(logic [31:0] v);
    @(negedge clk);
    hiWrEn = 1'b1; hiWrData = v;
    @(negedge clk);
    hiWrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 dstOut", dstOut, 0);
    chk("R11 hiRd", hiRd, 0);
    chk("R11 flags", flags, 0);
    chk("R11 busy/done/err", {busy, done, divErr}, 0);
  endtask

  task automatic tMul(string tag, bit sgn, logic [31:0] a, logic [31:0] b);
    int lat;
    logic [63:0] p;
    p = expMul(sgn, a, b);
    runOp(1'b0, sgn, a, b, lat);
    chk({tag, " low word"}, dstOut, p[31:0]);
    chk({tag, " high word"}, hiRd, p[63:32]);
    chk("R5 flags after multiply", flags, expFlags(p[31:0]));
    chk("R8 multiply latency", lat, 2);
    chk("R6 no error on multiply", divErr, 0);
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
  endtask

  task automatic tDiv(string tag, bit sgn, logic [31:0] hi, logic [31:0] lo, logic [31:0] dv);
    int lat;
    bit flt;
    logic [31:0] q, r, oldDst, oldHi;
    logic [3:0] oldFlags;
    writeHi(hi);
    chk("R9 high-word load", hiRd, hi);
    oldDst = dstOut; oldHi = hiRd; oldFlags = flags;
    expDiv(sgn, hi, lo, dv, flt, q, r);
    runOp(1'b1, sgn, lo, dv, lat);
    chk({tag, " divErr"}, divErr, flt);
    if (flt) begin
      chk({tag, " dst kept"}, dstOut, oldDst);
      chk({tag, " high kept"}, hiRd, oldHi);
      chk({tag, " flags kept"}, flags, oldFlags);
      chk("R8 fault latency", lat, 1);
    end else begin
      chk({tag, " quotient"}, dstOut, q);
      chk({tag, " remainder"}, hiRd, r);
      chk("R5 flags after divide", flags, expFlags(q));
      chk("R8 divide latency", lat, 33);
    end
  endtask

  task automatic tBusyIgnore();
    int lat;
    writeHi(32'd0);
    @(negedge clk);
    start = 1'b1; opSel = 1'b1; isSigned = 1'b0; dstIn = 32'd100; srcIn = 32'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy during divide", busy, 1);
    start = 1'b1; opSel = 1'b0; dstIn = 32'd3; srcIn = 32'd3;
    hiWrEn = 1'b1; hiWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    start = 1'b0; hiWrEn = 1'b0;
    chk("R10 high word not loaded while busy", hiRd, 0);
    lat = 4;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 latency unchanged", lat, 33);
    chk("R10 quotient unchanged", dstOut, 14);
    chk("R10 remainder unchanged", hiRd, 2);
    @(negedge clk);
    chk("R10 no second operation", {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();

    tMul("R1 unsigned", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tMul("R1 unsigned", 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
    tMul("R2 signed neg*pos", 1'b1, 32'hFFFF_FFFD, 32'd5);
    tMul("R2 signed neg*neg", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tMul("R2 R5 signed zero low", 1'b1, 32'h8000_0000, 32'h8000_0000);
    tMul("R1 R5 zero operand", 1'b0, 32'd0, 32'h7777_0001);

    tDiv("R3 unsigned small", 1'b0, 32'd0, 32'd100, 32'd7);
    tDiv("R3 unsigned wide", 1'b0, 32'd5, 32'h0000_1234, 32'h10);
    tDiv("R4 signed neg dividend", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7);
    tDiv("R4 signed neg divisor", 1'b1, 32'd0, 32'd100, 32'hFFFF_FFF9);
    tDiv("R4 signed both neg", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
    tMul("R2 set negative flag", 1'b1, 32'hFFFF_FFFF, 32'd1);
    tDiv("R6 divide by zero", 1'b0, 32'h0000_0003, 32'd9, 32'd0);
    tDiv("R7 unsigned overflow", 1'b0, 32'h20, 32'd0, 32'h10);
    tDiv("R7 signed overflow", 1'b1, 32'hFFFF_FFF0, 32'd0, 32'd4);

    tBusyIgnore();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule